// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block sits on the host side of a byte-wide flash device's command interface. It takes one request at a time: a single byte program, a block erase, or one element of a batch of byte programs. For each request it issues the two command writes, then polls the device status until the device reports ready. It turns the status into a result code, clears the device status after an error, and puts the device back into array-read mode. A one-cycle `done` pulse returns the result code to the requester.

The device bus is a simple synchronous port. A write takes one cycle with `bus_we` high; `bus_addr` and `bus_wdata` are valid in that cycle. A read takes one cycle with `bus_rd` high, and `bus_rdata` is sampled at the clock edge that ends that cycle. Between two status reads the strobe stays low for `POLL_GAP` cycles, so the device re-captures its status on every poll.

In a batch, every element except the last only waits for ready and reports 0, and leaves the device in status mode. The error bits the device accumulates are decoded once, after the last element. If ready never appears, polling gives up after `POLL_LIMIT` unready reads.

Top module: `flash_prog_seq`

## Requirements
- R1: Operation code 0 (single program) or 2 (batch program) writes 40H, then in the next cycle writes the request data, both at the request address. Code 3 is handled as code 0.
- R2: Operation code 1 (erase) writes 20H, then in the next cycle writes D0H, both at the request address.
- R3: After the second write, the block reads status in one-cycle `bus_rd` pulses. Exactly `POLL_GAP` idle cycles separate two reads. Error bits seen while status bit 7 is 0 have no effect.
- R4: When status bit 7 reads 1, the result is chosen in this priority order, with bits 2..0 ignored:
  - bit 3 gives 1 (voltage low);
  - bits 4 and 5 both set give 2 (sequence error);
  - bit 5 alone gives 3 (erase failure);
  - bit 4 alone gives 4 (program failure);
  - no error bit gives 0.
- R5: A result from 1 to 4 makes the block write 50H in the cycle after the ready read, before the final FFH write.
- R6: Every request except a non-final batch element ends with a write of FFH at the request address, followed by a cycle with `done` high and `result` valid. `busy` is high from the cycle after acceptance through the `done` cycle, and low otherwise.
- R7: A batch element with `req_last` low ends with `done` and result 0 in the cycle after the ready read, whatever the error bits. It writes neither 50H nor FFH.
- R8: After `POLL_LIMIT` reads without bit 7 set, the block skips the 50H write, writes FFH, and reports result 5.
- R9: After reset the block is idle: `busy`, `done`, `bus_we` and `bus_rd` are low and `result` is 0.
- R10: `req_valid` is accepted only while `busy` is low. A request presented while busy changes no bus cycle of the operation in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_op | input | 2 | 0 program, 1 erase, 2 batch program, 3 as 0 |
| req_addr | input | ADDR_W | Byte address, or an address inside the block to erase |
| req_data | input | DATA_W | Byte to program |
| req_last | input | 1 | Marks the final element of a batch |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | Result code, valid with `done` |
| bus_we | output | 1 | Device write strobe, one cycle per write |
| bus_rd | output | 1 | Device read strobe, one cycle per status read |
| bus_addr | output | ADDR_W | Device address |
| bus_wdata | output | DATA_W | Device write data |
| bus_rdata | input | DATA_W | Device status, sampled at the end of a read cycle |

## Verification
The bench builds the block with `POLL_GAP` set to 3 and `POLL_LIMIT` set to 4. With these values the multi-cycle gap counter is the variant that gets exercised. A run that hits the timeout is only a handful of reads long, so both sides of the limit are covered: three unready reads followed by ready, and four unready reads ending in a timeout. The bench's device model returns a busy status with error bits set until it reports ready. This shows that errors are decoded only after ready.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

   typedef enum logic [1:0] {
      OP_PROG  = 2'd0,
      OP_ERASE = 2'd1,
      OP_BATCH = 2'd2,
      OP_RSVD  = 2'd3
   } op_e;

   typedef enum logic [2:0] {
      RES_OK      = 3'd0,
      RES_VLOW    = 3'd1,
      RES_SEQ     = 3'd2,
      RES_ERASE   = 3'd3,
      RES_PROG    = 3'd4,
      RES_TIMEOUT = 3'd5
   } res_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_CONFIRM,
      ST_POLL,
      ST_GAP,
      ST_CLEAR,
      ST_ARRAY,
      ST_DONE
   } seq_st_e;

   localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
   localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
   localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
   localparam logic [7:0] CMD_CLR_STATUS  = 8'h50;
   localparam logic [7:0] CMD_ARRAY_MODE  = 8'hFF;

   localparam int SR_READY     = 7;
   localparam int SR_ERASE_BAD = 5;
   localparam int SR_PROG_BAD  = 4;
   localparam int SR_VOLT_LOW  = 3;

endpackage

// File: rtl/flash_status_decode.sv
module flash_status_decode
   import flash_seq_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] status,
   output logic              ready,
   output res_e              code,
   output logic              is_err
);

   if (DATA_W < 8) begin : g_bad_width
      $error("flash_status_decode: DATA_W must be at least 8");
   end

   // bit 6 and bits 2..0 carry no meaning for the decode
   logic unused_status_bits;
   if (DATA_W > 8) begin : g_wide
      assign unused_status_bits = ^{status[DATA_W-1:8], status[6], status[2:0]};
   end else begin : g_narrow
      assign unused_status_bits = ^{status[6], status[2:0]};
   end

   always_comb begin
      ready = status[SR_READY];
      if (status[SR_VOLT_LOW]) begin
         code = RES_VLOW;
      end else if (status[SR_ERASE_BAD] && status[SR_PROG_BAD]) begin
         code = RES_SEQ;
      end else if (status[SR_ERASE_BAD]) begin
         code = RES_ERASE;
      end else if (status[SR_PROG_BAD]) begin
         code = RES_PROG;
      end else begin
         code = RES_OK;
      end
      is_err = (code != RES_OK);
   end

endmodule

// File: rtl/flash_poll_pacer.sv
module flash_poll_pacer #(
   parameter int POLL_GAP   = 2,
   parameter int POLL_LIMIT = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic miss,
   input  logic in_gap,
   output logic gap_done,
   output logic last_try
);

   localparam int MISS_W = $clog2(POLL_LIMIT + 1);
   localparam logic [MISS_W-1:0] LAST_MISS = MISS_W'(POLL_LIMIT - 1);

   if (POLL_GAP < 1) begin : g_bad_gap
      $error("flash_poll_pacer: POLL_GAP must be at least 1");
   end
   if (POLL_LIMIT < 1) begin : g_bad_limit
      $error("flash_poll_pacer: POLL_LIMIT must be at least 1");
   end

   logic [MISS_W-1:0] miss_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         miss_cnt <= '0;
      end else if (miss) begin
         miss_cnt <= miss_cnt + 1'b1;
      end
   end

   assign last_try = (miss_cnt == LAST_MISS);

   if (POLL_GAP == 1) begin : g_gap_single
      logic unused_in_gap;
      assign unused_in_gap = in_gap;
      assign gap_done      = 1'b1;
   end else begin : g_gap_count
      localparam int GAP_W = $clog2(POLL_GAP);
      localparam logic [GAP_W-1:0] GAP_END = GAP_W'(POLL_GAP - 1);
      logic [GAP_W-1:0] gap_cnt;

      always_ff @(posedge clk) begin
         if (!rst_n || !in_gap) begin
            gap_cnt <= '0;
         end else begin
            gap_cnt <= gap_cnt + 1'b1;
         end
      end

      assign gap_done = in_gap && (gap_cnt == GAP_END);
   end

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
   import flash_seq_pkg::*;
#(
   parameter int ADDR_W     = 17,
   parameter int DATA_W     = 8,
   parameter int POLL_GAP   = 2,
   parameter int POLL_LIMIT = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic              req_last,
   output logic              busy,
   output logic              done,
   output logic [2:0]        result,
   output logic              bus_we,
   output logic              bus_rd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata
);

   seq_st_e           st_q, st_d;
   op_e               op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              last_q;
   res_e              res_q, res_d;

   logic              sr_ready;
   res_e              sr_code;
   logic              sr_err;
   logic              gap_done;
   logic              last_try;

   logic is_erase;
   logic batch_mid;
   assign is_erase  = (op_q == OP_ERASE);
   assign batch_mid = (op_q == OP_BATCH) && !last_q;

   flash_status_decode #(
      .DATA_W (DATA_W)
   ) u_decode (
      .status (bus_rdata),
      .ready  (sr_ready),
      .code   (sr_code),
      .is_err (sr_err)
   );

   flash_poll_pacer #(
      .POLL_GAP   (POLL_GAP),
      .POLL_LIMIT (POLL_LIMIT)
   ) u_pacer (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (st_q == ST_CONFIRM),
      .miss     ((st_q == ST_POLL) && !sr_ready),
      .in_gap   (st_q == ST_GAP),
      .gap_done (gap_done),
      .last_try (last_try)
   );

   // next state and result
   always_comb begin
      st_d  = st_q;
      res_d = res_q;
      unique case (st_q)
         ST_IDLE:    if (req_valid) st_d = ST_SETUP;
         ST_SETUP:   st_d = ST_CONFIRM;
         ST_CONFIRM: st_d = ST_POLL;
         ST_POLL: begin
            if (sr_ready) begin
               if (batch_mid) begin
                  res_d = RES_OK;
                  st_d  = ST_DONE;
               end else begin
                  res_d = sr_code;
                  st_d  = sr_err ? ST_CLEAR : ST_ARRAY;
               end
            end else if (last_try) begin
               res_d = RES_TIMEOUT;
               st_d  = ST_ARRAY;
            end else begin
               st_d = ST_GAP;
            end
         end
         ST_GAP:   if (gap_done) st_d = ST_POLL;
         ST_CLEAR: st_d = ST_ARRAY;
         ST_ARRAY: st_d = ST_DONE;
         ST_DONE:  st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         op_q   <= OP_PROG;
         addr_q <= '0;
         data_q <= '0;
         last_q <= 1'b0;
         res_q  <= RES_OK;
      end else begin
         st_q  <= st_d;
         res_q <= res_d;
         if (st_q == ST_IDLE && req_valid) begin
            op_q   <= op_e'(req_op);
            addr_q <= req_addr;
            data_q <= req_data;
            last_q <= req_last;
         end
      end
   end

   // device bus, decoded from state
   always_comb begin
      bus_we    = 1'b0;
      bus_rd    = 1'b0;
      bus_wdata = '0;
      unique case (st_q)
         ST_SETUP: begin
            bus_we    = 1'b1;
            bus_wdata = is_erase ? DATA_W'(CMD_ERASE_SETUP) : DATA_W'(CMD_PROG_SETUP);
         end
         ST_CONFIRM: begin
            bus_we    = 1'b1;
            bus_wdata = is_erase ? DATA_W'(CMD_ERASE_GO) : data_q;
         end
         ST_POLL: bus_rd = 1'b1;
         ST_CLEAR: begin
            bus_we    = 1'b1;
            bus_wdata = DATA_W'(CMD_CLR_STATUS);
         end
         ST_ARRAY: begin
            bus_we    = 1'b1;
            bus_wdata = DATA_W'(CMD_ARRAY_MODE);
         end
         default: ;
      endcase
   end

   assign bus_addr = addr_q;
   assign busy     = (st_q != ST_IDLE);
   assign done     = (st_q == ST_DONE);
   assign result   = res_q;

endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk #(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic [2:0]        result,
   input logic              bus_we,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata
);

   localparam logic [DATA_W-1:0] W40 = DATA_W'(8'h40);
   localparam logic [DATA_W-1:0] W20 = DATA_W'(8'h20);
   localparam logic [DATA_W-1:0] WD0 = DATA_W'(8'hD0);
   localparam logic [DATA_W-1:0] W50 = DATA_W'(8'h50);
   localparam logic [DATA_W-1:0] WFF = DATA_W'(8'hFF);

   AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_rd)); // R3

   AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> !bus_rd); // R3

   AST_PROG_DATA_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_wdata == W40 && !$past(bus_we)) |=> (bus_we && $stable(bus_addr))); // R1

   AST_ERASE_CONFIRM_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_wdata == W20 && !$past(bus_we)) |=>
         (bus_we && bus_wdata == WD0 && $stable(bus_addr))); // R2

   AST_CLEAR_THEN_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_wdata == W50 && $past(bus_rd)) |=> (bus_we && bus_wdata == WFF)); // R5

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R6

   AST_DONE_AFTER_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (($past(bus_we) && $past(bus_wdata) == WFF) || $past(bus_rd))); // R6

   AST_STROBE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we || bus_rd || done) |-> busy); // R6

   AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (result <= 3'd5)); // R4

endmodule

bind flash_prog_seq flash_prog_seq_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .done      (done),
   .result    (result),
   .bus_we    (bus_we),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata)
);

// File: tb/flash_prog_seq_bench.sv
`timescale 1ns/100ps
module flash_prog_seq_bench;

   localparam int AW  = 17;
   localparam int DW  = 8;
   localparam int GAP = 3;
   localparam int LIM = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid;
   logic [1:0]    req_op;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_data;
   logic          req_last;
   logic          busy, done;
   logic [2:0]    result;
   logic          bus_we, bus_rd;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic [DW-1:0] bus_rdata;

   always #2.5 clk = ~clk;

   flash_prog_seq #(
      .ADDR_W (AW), .DATA_W (DW), .POLL_GAP (GAP), .POLL_LIMIT (LIM)
   ) u_flash_prog_seq (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_op (req_op),
      .req_addr (req_addr), .req_data (req_data), .req_last (req_last),
      .busy (busy), .done (done), .result (result),
      .bus_we (bus_we), .bus_rd (bus_rd), .bus_addr (bus_addr),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata)
   );

   // behavioural device: unready status for dev_nbusy reads, then dev_final
   int        rd_total = 0;
   int        rd_base  = 0;
   int        dev_nbusy = 0;
   logic [7:0] dev_final = 8'h80;
   logic [7:0] dev_wait  = 8'h38;   // error bits set while not ready (R3)

   always @(posedge clk) if (bus_rd) rd_total <= rd_total + 1;
   assign bus_rdata = ((rd_total - rd_base) < dev_nbusy) ? dev_wait : dev_final;

   typedef struct {
      bit            we;
      bit            rd;
      logic [AW-1:0] addr;
      logic [7:0]    wd;
      bit            bsy;
      bit            dn;
      logic [2:0]    res;
      string         tag;
   } cyc_t;

   cyc_t exp_q[$];
   int   checks = 0;
   int   errors = 0;
   bit   run_cmp = 1'b0;

   function automatic cyc_t mk(bit we, bit rd, logic [AW-1:0] a, logic [7:0] wd,
                               bit bsy, bit dn, logic [2:0] res, string tag);
      cyc_t c;
      c.we = we; c.rd = rd; c.addr = a; c.wd = wd;
      c.bsy = bsy; c.dn = dn; c.res = res; c.tag = tag;
      return c;
   endfunction

   function automatic logic [2:0] exp_code(logic [7:0] s);
      if (s[3])              return 3'd1;
      else if (s[5] && s[4]) return 3'd2;
      else if (s[5])         return 3'd3;
      else if (s[4])         return 3'd4;
      else                   return 3'd0;
   endfunction

   // reference comparison on every clock
   always @(posedge clk) begin
      cyc_t e;
      #1;
      if (run_cmp) begin
         if (exp_q.size() > 0) e = exp_q.pop_front();
         else e = mk(0, 0, '0, 8'h00, 0, 0, 3'd0, "R6");
         checks++;
         if (bus_we != e.we || bus_rd != e.rd || busy != e.bsy || done != e.dn ||
             (e.we && (bus_addr != e.addr || bus_wdata != e.wd)) ||
             (e.dn && result != e.res)) begin
            errors++;
            $display("FAIL %s: we rd busy done=%b%b%b%b addr=%h wdata=%h result=%0d, expected %b%b%b%b addr=%h wdata=%h result=%0d",
                     e.tag, bus_we, bus_rd, busy, done, bus_addr, bus_wdata, result,
                     e.we, e.rd, e.bsy, e.dn, e.addr, e.wd, e.res);
         end
      end
   end

   task automatic run_op(input int op, input logic [AW-1:0] a, input logic [7:0] d,
                         input bit last, input int nbusy, input logic [7:0] fin,
                         input bit poke);
      string      tg;
      int         miss;
      bit         fin_done;
      logic [2:0] code;
      tg = (op == 1) ? "R2" : "R1";
      miss = 0;
      fin_done = 0;
      @(negedge clk);
      exp_q.push_back(mk(1, 0, a, (op == 1) ? 8'h20 : 8'h40, 1, 0, 3'd0, tg));
      exp_q.push_back(mk(1, 0, a, (op == 1) ? 8'hD0 : d, 1, 0, 3'd0, tg));
      while (!fin_done) begin
         exp_q.push_back(mk(0, 1, a, 8'h00, 1, 0, 3'd0, "R3"));
         if (miss < nbusy) begin
            miss++;
            if (miss == LIM) begin
               exp_q.push_back(mk(1, 0, a, 8'hFF, 1, 0, 3'd0, "R8"));
               exp_q.push_back(mk(0, 0, a, 8'h00, 1, 1, 3'd5, "R8"));
               fin_done = 1;
            end else begin
               for (int g = 0; g < GAP; g++)
                  exp_q.push_back(mk(0, 0, a, 8'h00, 1, 0, 3'd0, "R3"));
            end
         end else begin
            if (op == 2 && !last) begin
               exp_q.push_back(mk(0, 0, a, 8'h00, 1, 1, 3'd0, "R7"));
            end else begin
               code = exp_code(fin);
               if (code != 3'd0)
                  exp_q.push_back(mk(1, 0, a, 8'h50, 1, 0, 3'd0, "R5"));
               exp_q.push_back(mk(1, 0, a, 8'hFF, 1, 0, 3'd0, "R6"));
               exp_q.push_back(mk(0, 0, a, 8'h00, 1, 1, code, "R4"));
            end
            fin_done = 1;
         end
      end
      dev_nbusy = nbusy;
      dev_final = fin;
      rd_base   = rd_total;
      req_op    = op[1:0];
      req_addr  = a;
      req_data  = d;
      req_last  = last;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (poke) begin   // R10: requests while busy are not taken
         @(negedge clk);
         req_valid = 1'b1;
         req_op    = 2'd1;
         req_addr  = ~a;
         req_data  = ~d;
         repeat (2) @(negedge clk);
         req_valid = 1'b0;
      end
      wait (exp_q.size() == 0);
      repeat (2) @(negedge clk);
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL R6: watchdog expired, run did not complete");
      summary();
      $finish;
   end

   initial begin
      rst_n     = 1'b0;
      req_valid = 1'b0;
      req_op    = 2'd0;
      req_addr  = '0;
      req_data  = '0;
      req_last  = 1'b0;
      repeat (3) @(negedge clk);
      // R9: reset state
      checks++;
      if (busy || done || bus_we || bus_rd || result != 3'd0) begin
         errors++;
         $display("FAIL R9: busy done we rd result=%b%b%b%b %0d, expected 0000 0",
                  busy, done, bus_we, bus_rd, result);
      end
      rst_n = 1'b1;
      run_cmp = 1'b1;

      run_op(0, 17'h01234, 8'h5A, 1, 2, 8'h80, 0);   // R1 program ok
      run_op(0, 17'h1ABCD, 8'h40, 1, 0, 8'h80, 0);   // R1 data equal to setup code
      run_op(1, 17'h10000, 8'h00, 1, 0, 8'h87, 0);   // R2, R4 low bits masked
      run_op(1, 17'h04000, 8'h00, 1, 1, 8'hA0, 0);   // R4 erase fail, R5 clear
      run_op(0, 17'h00003, 8'hC3, 1, 0, 8'h90, 0);   // R4 program fail
      run_op(1, 17'h08000, 8'h00, 1, 0, 8'hB0, 0);   // R4 sequence error
      run_op(0, 17'h00010, 8'h11, 1, 0, 8'hB8, 0);   // R4 voltage low has priority
      run_op(0, 17'h00020, 8'h22, 1, 10, 8'h80, 0);  // R8 timeout
      run_op(1, 17'h0C000, 8'h00, 1, 3, 8'h80, 0);   // R8 one short of limit
      run_op(2, 17'h00100, 8'h01, 0, 1, 8'h90, 0);   // R7 batch element
      run_op(2, 17'h00101, 8'h02, 0, 0, 8'h90, 0);   // R7 batch element
      run_op(2, 17'h00102, 8'h03, 1, 0, 8'h90, 0);   // R7 final decode -> R4/R5
      run_op(3, 17'h00200, 8'h77, 1, 0, 8'h80, 0);   // R1 code 3 as program
      run_op(0, 17'h00300, 8'h99, 1, 2, 8'h80, 1);   // R10 request while busy

      run_cmp = 1'b0;
      summary();
      $finish;
   end

endmodule